// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block takes control of the instruction stream when a fault, a single-step trap or an external interrupt is pending at an instruction boundary. It chooses one event, decides which instruction address must be saved for the return, fetches the 64-bit gate descriptor of the event's vector from a descriptor table in memory, and pulls the handler's entry offset and code selector out of that descriptor. It then writes a return frame to the stack through a simple word write port and reports the new instruction pointer, code selector and stack values with a one-cycle completion pulse.

The core presents events for one cycle while the sequencer is idle and stalls on `busy`. Entry from user mode switches to the kernel stack segment and pointer taken from the task-state inputs and saves the old stack segment and pointer ahead of the usual three words. Entry from kernel mode keeps the current stack and saves three words. Vectors 0 to 31 belong to exceptions. Vectors 32 to 255 are left for external interrupts and other uses. A descriptor that does not fit below the table limit aborts the entry with an error pulse.

Top module: `exc_entry_seq`

## Requirements
- R1: With several events presented in the same idle cycle, a fault is taken over a trap and a trap over an external interrupt. The vector of the taken event alone selects the descriptor.
- R2: For a fault, the saved return address is `curr_ip`, the address of the faulting instruction.
- R3: A trap is taken whenever `insn_done` and `trap_flag` are both high, with vector `TRAP_VEC` (default 1). An interrupt is taken when `insn_done` and `irq_req` are both high. Both save `next_ip`. With no request, or with `insn_done` alone and no trap flag, nothing starts.
- R4: One cycle after acceptance, a single descriptor read is issued at table base plus eight times the vector. The base is `tbl_reg[47:16]` and the limit is `tbl_reg[15:0]`. `rd_data` is sampled one cycle after `rd_en`.
- R5: If eight times the vector plus 7 exceeds the limit, `err` pulses one cycle after acceptance. No read, no write and no `done` follow.
- R6: The entry point is descriptor bits 63:48 (upper half) joined with bits 15:0 (lower half). The code selector is bits 31:16. Both appear on `new_ip` and `new_cs`.
- R7: From user mode (`user_mode`=1), the stack becomes `kstk_ss`/`kstk_sp`. Five words are written in this order: old SS (zero-extended), old SP, flags, CS (zero-extended), return address. The first word goes to `kstk_sp`-4 and each following word 4 bytes lower.
- R8: From kernel mode, the stack is not switched. Three words are written in this order: flags, CS, return address. The first word goes to `sp_in`-4, stepping down by 4.
- R9: `done` is a single-cycle pulse in the cycle right after the last write. It comes with `new_ip`, `new_cs`, `new_ss` and `new_sp`, where `new_sp` is the address of the last word written.
- R10: After reset the block is idle, with `busy`, `rd_en`, `wr_en`, `done` and `err` all low.
- R11: While busy, new fault, trap or interrupt requests are ignored and do not change the frame or the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_req | input | 1 | Current instruction faults |
| fault_vec | input | 8 | Vector of the fault |
| insn_done | input | 1 | An instruction completed in this cycle |
| trap_flag | input | 1 | Single-step trap enable |
| irq_req | input | 1 | External interrupt pending |
| irq_vec | input | 8 | Vector of the interrupt |
| curr_ip | input | 32 | Address of the current instruction |
| next_ip | input | 32 | Address of the following instruction |
| flags_in | input | 32 | Flags word to save |
| cs_in | input | 16 | Current code selector |
| ss_in | input | 16 | Current stack segment |
| sp_in | input | 32 | Current stack pointer |
| user_mode | input | 1 | 1 when running in user mode |
| tbl_reg | input | 48 | Descriptor table base (47:16) and limit (15:0) |
| kstk_ss | input | 16 | Kernel stack segment from the task state |
| kstk_sp | input | 32 | Kernel stack pointer from the task state |
| busy | output | 1 | Sequencer is handling an event |
| rd_en | output | 1 | Descriptor read strobe |
| rd_addr | output | 32 | Descriptor byte address |
| rd_data | input | 64 | Descriptor returned one cycle after `rd_en` |
| wr_en | output | 1 | Stack write strobe |
| wr_addr | output | 32 | Stack write byte address |
| wr_data | output | 32 | Stack write word |
| done | output | 1 | Entry complete pulse |
| err | output | 1 | Descriptor beyond the table limit |
| new_ip | output | 32 | Handler entry point |
| new_cs | output | 16 | Handler code selector |
| new_ss | output | 16 | Stack segment after entry |
| new_sp | output | 32 | Stack pointer after entry |

## Verification
Events are drawn at random from every mix of fault, trap flag, completed instruction and interrupt request. The mixes with two or three sources at once separate the priority order, and the single sources separate the choice between `curr_ip` and `next_ip`. User and kernel entries are mixed so that the five-word switched frame and the three-word frame are each checked for order, addresses and final stack values. Table limits placed exactly at and one byte below the end of a descriptor separate a correct limit compare from an off-by-one. An entry during which requests are raised mid-sequence shows whether a busy sequencer wrongly restarts.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_PUSH,
        ST_DONE,
        ST_ERR
    } seq_state_e;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_FAULT,
        EV_TRAP,
        EV_IRQ
    } ev_kind_e;

endpackage

// File: rtl/exc_event_arb.sv
module exc_event_arb
    import exc_entry_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int VECW     = 8,
    parameter int TRAP_VEC = 1
) (
    input  logic            fault_req,
    input  logic [VECW-1:0] fault_vec,
    input  logic            insn_done,
    input  logic            trap_flag,
    input  logic            irq_req,
    input  logic [VECW-1:0] irq_vec,
    input  logic [XLEN-1:0] curr_ip,
    input  logic [XLEN-1:0] next_ip,
    output logic            ev_valid,
    output ev_kind_e        ev_kind,
    output logic [VECW-1:0] ev_vec,
    output logic [XLEN-1:0] ev_ret_ip
);

    // Priority: fault on this instruction, then step trap, then interrupt.
    always_comb begin
        ev_kind   = EV_NONE;
        ev_vec    = '0;
        ev_ret_ip = next_ip;
        if (fault_req) begin
            ev_kind   = EV_FAULT;
            ev_vec    = fault_vec;
            ev_ret_ip = curr_ip;
        end else if (insn_done && trap_flag) begin
            ev_kind   = EV_TRAP;
            ev_vec    = VECW'(TRAP_VEC);
        end else if (insn_done && irq_req) begin
            ev_kind   = EV_IRQ;
            ev_vec    = irq_vec;
        end
        ev_valid = (ev_kind != EV_NONE);
    end

endmodule

// File: rtl/exc_gate_unit.sv
module exc_gate_unit #(
    parameter int XLEN = 32,
    parameter int SELW = 16,
    parameter int VECW = 8,
    parameter int LIMW = 16
) (
    input  logic [XLEN+LIMW-1:0] tbl_reg,
    input  logic [VECW-1:0]      vec,
    input  logic [2*XLEN-1:0]    desc,
    output logic [XLEN-1:0]      desc_addr,
    output logic                 over_limit,
    output logic [XLEN-1:0]      entry_ip,
    output logic [SELW-1:0]      entry_sel
);

    localparam int DESCW      = 2 * XLEN;
    localparam int HALF       = XLEN / 2;
    localparam int SLOT_BYTES = DESCW / 8;
    localparam int SLOT_SHIFT = $clog2(SLOT_BYTES);

    logic [XLEN-1:0] tbl_base;
    logic [XLEN-1:0] tbl_limit;
    logic [XLEN-1:0] slot_off;
    logic [XLEN-1:0] slot_last;
    logic            unused_attr;

    assign tbl_base  = tbl_reg[XLEN+LIMW-1:LIMW];
    assign tbl_limit = XLEN'(tbl_reg[LIMW-1:0]);
    assign slot_off  = XLEN'(vec) << SLOT_SHIFT;
    assign slot_last = slot_off + XLEN'(SLOT_BYTES - 1);

    assign desc_addr  = tbl_base + slot_off;
    assign over_limit = (slot_last > tbl_limit);

    // Offset halves sit at the two ends of the descriptor, selector above the low half.
    assign entry_ip    = {desc[DESCW-1 -: HALF], desc[HALF-1:0]};
    assign entry_sel   = desc[XLEN-1 -: SELW];
    assign unused_attr = ^desc[DESCW-HALF-1:XLEN];

endmodule

// File: rtl/exc_frame_word.sv
module exc_frame_word #(
    parameter int XLEN = 32,
    parameter int SELW = 16,
    parameter int IDXW = 3
) (
    input  logic [IDXW-1:0] idx,
    input  logic [SELW-1:0] old_ss,
    input  logic [XLEN-1:0] old_sp,
    input  logic [XLEN-1:0] flags,
    input  logic [SELW-1:0] old_cs,
    input  logic [XLEN-1:0] ret_ip,
    output logic [XLEN-1:0] word
);

    // Slot order is the push order; kernel entries start at slot 2.
    always_comb begin
        case (idx)
            IDXW'(0): word = XLEN'(old_ss);
            IDXW'(1): word = old_sp;
            IDXW'(2): word = flags;
            IDXW'(3): word = XLEN'(old_cs);
            default:  word = ret_ip;
        endcase
    end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int SELW     = 16,
    parameter int VECW     = 8,
    parameter int LIMW     = 16,
    parameter int TRAP_VEC = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fault_req,
    input  logic [VECW-1:0]      fault_vec,
    input  logic                 insn_done,
    input  logic                 trap_flag,
    input  logic                 irq_req,
    input  logic [VECW-1:0]      irq_vec,
    input  logic [XLEN-1:0]      curr_ip,
    input  logic [XLEN-1:0]      next_ip,
    input  logic [XLEN-1:0]      flags_in,
    input  logic [SELW-1:0]      cs_in,
    input  logic [SELW-1:0]      ss_in,
    input  logic [XLEN-1:0]      sp_in,
    input  logic                 user_mode,
    input  logic [XLEN+LIMW-1:0] tbl_reg,
    input  logic [SELW-1:0]      kstk_ss,
    input  logic [XLEN-1:0]      kstk_sp,
    output logic                 busy,
    output logic                 rd_en,
    output logic [XLEN-1:0]      rd_addr,
    input  logic [2*XLEN-1:0]    rd_data,
    output logic                 wr_en,
    output logic [XLEN-1:0]      wr_addr,
    output logic [XLEN-1:0]      wr_data,
    output logic                 done,
    output logic                 err,
    output logic [XLEN-1:0]      new_ip,
    output logic [SELW-1:0]      new_cs,
    output logic [SELW-1:0]      new_ss,
    output logic [XLEN-1:0]      new_sp
);

    localparam int FRAME_WORDS  = 5;
    localparam int KERNEL_FIRST = 2;
    localparam int IDXW         = $clog2(FRAME_WORDS);
    localparam int WORD_BYTES   = XLEN / 8;

    typedef struct packed {
        seq_state_e      st;
        logic [XLEN-1:0] ret_ip;
        logic [SELW-1:0] old_ss;
        logic [XLEN-1:0] old_sp;
        logic [XLEN-1:0] flags;
        logic [SELW-1:0] old_cs;
        logic [XLEN-1:0] sp;
        logic [SELW-1:0] ss;
        logic [XLEN-1:0] desc_addr;
        logic [XLEN-1:0] entry_ip;
        logic [SELW-1:0] entry_sel;
        logic [IDXW-1:0] idx;
    } seq_t;

    seq_t r_q, r_d;

    logic            ev_valid;
    ev_kind_e        ev_kind;
    logic [VECW-1:0] ev_vec;
    logic [XLEN-1:0] ev_ret_ip;
    logic [XLEN-1:0] g_addr;
    logic            g_over;
    logic [XLEN-1:0] g_ip;
    logic [SELW-1:0] g_sel;
    logic [XLEN-1:0] frame_word;
    logic            unused_kind;

    assign unused_kind = ^ev_kind;

    exc_event_arb #(
        .XLEN(XLEN), .VECW(VECW), .TRAP_VEC(TRAP_VEC)
    ) u_arb (
        .fault_req (fault_req),
        .fault_vec (fault_vec),
        .insn_done (insn_done),
        .trap_flag (trap_flag),
        .irq_req   (irq_req),
        .irq_vec   (irq_vec),
        .curr_ip   (curr_ip),
        .next_ip   (next_ip),
        .ev_valid  (ev_valid),
        .ev_kind   (ev_kind),
        .ev_vec    (ev_vec),
        .ev_ret_ip (ev_ret_ip)
    );

    exc_gate_unit #(
        .XLEN(XLEN), .SELW(SELW), .VECW(VECW), .LIMW(LIMW)
    ) u_gate (
        .tbl_reg    (tbl_reg),
        .vec        (ev_vec),
        .desc       (rd_data),
        .desc_addr  (g_addr),
        .over_limit (g_over),
        .entry_ip   (g_ip),
        .entry_sel  (g_sel)
    );

    exc_frame_word #(
        .XLEN(XLEN), .SELW(SELW), .IDXW(IDXW)
    ) u_word (
        .idx    (r_q.idx),
        .old_ss (r_q.old_ss),
        .old_sp (r_q.old_sp),
        .flags  (r_q.flags),
        .old_cs (r_q.old_cs),
        .ret_ip (r_q.ret_ip),
        .word   (frame_word)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (ev_valid) begin
                    r_d.ret_ip    = ev_ret_ip;
                    r_d.old_ss    = ss_in;
                    r_d.old_sp    = sp_in;
                    r_d.flags     = flags_in;
                    r_d.old_cs    = cs_in;
                    r_d.desc_addr = g_addr;
                    r_d.sp        = user_mode ? kstk_sp : sp_in;
                    r_d.ss        = user_mode ? kstk_ss : ss_in;
                    r_d.idx       = user_mode ? '0 : IDXW'(KERNEL_FIRST);
                    r_d.st        = g_over ? ST_ERR : ST_FETCH;
                end
            end
            ST_FETCH: r_d.st = ST_WAIT;
            ST_WAIT: begin
                r_d.entry_ip  = g_ip;
                r_d.entry_sel = g_sel;
                r_d.st        = ST_PUSH;
            end
            ST_PUSH: begin
                r_d.sp = r_q.sp - XLEN'(WORD_BYTES);
                if (r_q.idx == IDXW'(FRAME_WORDS - 1)) begin
                    r_d.st = ST_DONE;
                end else begin
                    r_d.idx = r_q.idx + IDXW'(1);
                end
            end
            ST_DONE: r_d.st = ST_IDLE;
            ST_ERR:  r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy    = (r_q.st != ST_IDLE);
    assign rd_en   = (r_q.st == ST_FETCH);
    assign rd_addr = r_q.desc_addr;
    assign wr_en   = (r_q.st == ST_PUSH);
    assign wr_addr = r_q.sp - XLEN'(WORD_BYTES);
    assign wr_data = frame_word;
    assign done    = (r_q.st == ST_DONE);
    assign err     = (r_q.st == ST_ERR);
    assign new_ip  = r_q.entry_ip;
    assign new_cs  = r_q.entry_sel;
    assign new_ss  = r_q.ss;
    assign new_sp  = r_q.sp;

endmodule

module exc_entry_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            rd_en,
    input logic            wr_en,
    input logic [XLEN-1:0] wr_addr,
    input logic            done,
    input logic            err
);

    localparam int WORD_BYTES = XLEN / 8;

    logic [2:0] push_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || rd_en) push_cnt <= '0;
        else if (wr_en)      push_cnt <= push_cnt + 3'd1;
    end

    a_r4_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);

    a_r5_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!rd_en && !wr_en && !done));

    a_r5_err_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !$past(busy));

    a_r7_push_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) - XLEN'(WORD_BYTES)));

    a_r8_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (push_cnt == 3'd3 || push_cnt == 3'd5));

    a_r9_done_after_push: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(wr_en));

    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_en, wr_en, done, err}));

    a_r11_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en || wr_en || done || err) |-> busy);

endmodule

bind exc_entry_seq exc_entry_chk #(.XLEN(XLEN)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .done    (done),
    .err     (err)
);

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fault_req, insn_done, trap_flag, irq_req, user_mode;
    logic [7:0]  fault_vec, irq_vec;
    logic [31:0] curr_ip, next_ip, flags_in, sp_in, kstk_sp;
    logic [15:0] cs_in, ss_in, kstk_ss;
    logic [47:0] tbl_reg;
    logic        busy, rd_en, wr_en, done, err;
    logic [31:0] rd_addr, wr_addr, wr_data, new_ip, new_sp;
    logic [63:0] rd_data = '0;
    logic [15:0] new_cs, new_ss;

    int nchk  = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    exc_entry_seq dut (
        .clk(clk), .rst_n(rst_n),
        .fault_req(fault_req), .fault_vec(fault_vec),
        .insn_done(insn_done), .trap_flag(trap_flag),
        .irq_req(irq_req), .irq_vec(irq_vec),
        .curr_ip(curr_ip), .next_ip(next_ip),
        .flags_in(flags_in), .cs_in(cs_in), .ss_in(ss_in), .sp_in(sp_in),
        .user_mode(user_mode), .tbl_reg(tbl_reg),
        .kstk_ss(kstk_ss), .kstk_sp(kstk_sp),
        .busy(busy), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .done(done), .err(err),
        .new_ip(new_ip), .new_cs(new_cs), .new_ss(new_ss), .new_sp(new_sp)
    );

    function automatic logic [63:0] desc_of(input logic [31:0] a);
        return {(a * 32'h9E3779B1) ^ 32'h5A5A0F0F, (~a) ^ 32'h13572468};
    endfunction

    // Memory model: one-cycle read latency.
    always @(posedge clk) if (rd_en) rd_data <= desc_of(rd_addr);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    endtask

    task automatic rand_ctx();
        curr_ip  = $urandom;
        next_ip  = curr_ip + 32'd1 + ($urandom % 15);
        flags_in = $urandom;
        cs_in    = 16'($urandom);
        ss_in    = 16'($urandom);
        sp_in    = {$urandom, 2'b00} >> 2 << 2;
        kstk_ss  = 16'($urandom);
        kstk_sp  = ($urandom | 32'h100) & 32'hFFFF_FFFC;
        tbl_reg  = {$urandom, 16'h07FF};
    endtask

    task automatic run_event(input bit noise);
        bit          any = 1'b1;
        bit          ex_err;
        logic [7:0]  ev = '0;
        logic [31:0] ret = '0;
        string       rtag = "R3";
        logic [31:0] da;
        logic [63:0] dsc;
        logic [31:0] fw[5];
        logic [31:0] sp0;
        int          nexp, nw = 0, nrd = 0, rdk = 0, lastk = 0, dk = 0, ek = 0;
        logic [31:0] wa[8];
        logic [31:0] wdv[8];
        logic [31:0] rda = '0;
        string       stag;

        if (fault_req) begin
            ev = fault_vec; ret = curr_ip; rtag = "R2";
        end else if (insn_done && trap_flag) begin
            ev = 8'd1; ret = next_ip;
        end else if (insn_done && irq_req) begin
            ev = irq_vec; ret = next_ip;
        end else begin
            any = 1'b0;
        end

        if (!any) begin
            for (int k = 1; k <= 4; k++) begin
                @(negedge clk);
                if (k == 1) begin fault_req = 0; insn_done = 0; irq_req = 0; end
                if (busy || rd_en || err) nrd++;
            end
            chk("R3 no event starts nothing", nrd, 0);
            return;
        end

        ex_err = ({24'd0, ev} * 32'd8 + 32'd7) > {16'd0, tbl_reg[15:0]};
        da     = tbl_reg[47:16] + {24'd0, ev} * 32'd8;
        dsc    = desc_of(da);
        if (user_mode) begin
            fw[0] = {16'd0, ss_in}; fw[1] = sp_in; fw[2] = flags_in;
            fw[3] = {16'd0, cs_in}; fw[4] = ret; nexp = 5; sp0 = kstk_sp; stag = "R7";
        end else begin
            fw[0] = flags_in; fw[1] = {16'd0, cs_in}; fw[2] = ret;
            nexp = 3; sp0 = sp_in; stag = "R8";
        end

        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            if (k == 1) begin fault_req = 0; insn_done = 0; irq_req = 0; end
            if (noise && k == 3) begin fault_req = 1; insn_done = 1; irq_req = 1; end
            if (noise && k == 4) begin fault_req = 0; insn_done = 0; irq_req = 0; end
            if (rd_en) begin nrd++; rda = rd_addr; rdk = k; end
            if (wr_en && nw < 8) begin wa[nw] = wr_addr; wdv[nw] = wr_data; nw++; lastk = k; end
            if (done) begin dk = k; break; end
            if (err)  begin ek = k; break; end
        end

        if (ex_err) begin
            chk("R5 err one cycle after accept", ek, 1);
            chk("R5 no read or write", nrd + nw + dk, 0);
        end else begin
            chk("R1/R4 descriptor address", rda, da);
            chk("R4 single read in first cycle", {nrd, rdk}, {32'd1, 32'd1});
            chk({stag, " word count"}, nw, nexp);
            for (int i = 0; i < nexp && i < nw; i++) begin
                chk({stag, " push address"}, wa[i], sp0 - 32'd4 * (i + 1));
                chk({stag, " push data"}, wdv[i], fw[i]);
            end
            if (nw == nexp) chk({rtag, " saved return"}, wdv[nexp-1], ret);
            chk("R9 done right after last push", {dk, dk}, {lastk + 1, 3 + nexp});
            chk("R6 entry point", new_ip, {dsc[63:48], dsc[15:0]});
            chk("R6 code selector", new_cs, dsc[31:16]);
            chk({stag, " new stack pointer"}, new_sp, sp0 - 32'd4 * nexp);
            chk({stag, " new stack segment"}, new_ss, user_mode ? kstk_ss : ss_in);
            if (noise) chk("R11 requests ignored while busy", nw, nexp);
        end
        @(negedge clk);
        chk("R9 single pulse and idle", {done, err, busy}, 3'b000);
    endtask

    initial begin
        #1_000_000;
        nfail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; fault_req = 0; insn_done = 0; trap_flag = 0; irq_req = 0;
        fault_vec = 0; irq_vec = 0; user_mode = 0;
        rand_ctx();
        repeat (3) @(negedge clk);
        chk("R10 reset idle", {busy, rd_en, wr_en, done, err}, 5'b0);
        rst_n = 1;
        @(negedge clk);
        chk("R10 idle after reset", {busy, rd_en, wr_en, done, err}, 5'b0);

        // R1: all three sources at once, fault wins.
        @(negedge clk); rand_ctx();
        fault_req = 1; fault_vec = 8'd13; insn_done = 1; trap_flag = 1;
        irq_req = 1; irq_vec = 8'd40; user_mode = 1;
        run_event(0);
        // R1: trap beats interrupt, kernel mode.
        @(negedge clk); rand_ctx();
        insn_done = 1; trap_flag = 1; irq_req = 1; irq_vec = 8'd77; user_mode = 0;
        run_event(0);
        // R3: interrupt alone.
        @(negedge clk); rand_ctx();
        trap_flag = 0; insn_done = 1; irq_req = 1; irq_vec = 8'd40; user_mode = 1;
        run_event(0);
        // R5: limit exactly at descriptor end, then one byte short.
        @(negedge clk); rand_ctx(); tbl_reg[15:0] = 16'd327;
        insn_done = 1; irq_req = 1; irq_vec = 8'd40; user_mode = 0;
        run_event(0);
        @(negedge clk); rand_ctx(); tbl_reg[15:0] = 16'd326;
        insn_done = 1; irq_req = 1; irq_vec = 8'd40;
        run_event(0);
        // R11: requests raised mid-sequence.
        @(negedge clk); rand_ctx();
        fault_req = 1; fault_vec = 8'd14; user_mode = 1;
        run_event(1);
        // R3: completed instruction with no trap and no interrupt.
        @(negedge clk); rand_ctx();
        insn_done = 1; trap_flag = 0; irq_req = 0;
        run_event(0);

        for (int n = 0; n < 200; n++) begin
            @(negedge clk); rand_ctx();
            if ($urandom % 4 == 0) tbl_reg[15:0] = 16'($urandom % 2048);
            fault_req = ($urandom % 3 == 0);
            fault_vec = 8'($urandom % 32);
            insn_done = ($urandom % 4 != 0);
            trap_flag = ($urandom % 3 == 0);
            irq_req   = ($urandom % 2 == 0);
            irq_vec   = 8'(32 + $urandom % 224);
            user_mode = $urandom % 2;
            run_event(n % 17 == 5);
        end

        summary();
        $finish;
    end

endmodule